// File: doc/BRIEF.md
# Three-Channel PWM Timer Counter

This block holds three identical timer channels behind a small memory-mapped register port. Each channel has an up-counter fed by an optional power-of-two prescaler. In interval mode the counter wraps at a programmable limit, which sets the period of a pulse-width-modulated waveform. A match value sets how many ticks of that period the waveform spends at its active level.

Software sets the period, duty point, prescale and polarity of a channel while the channel is stopped, pulses its counter reset and then clears the stop bit. A fresh period begins from count zero. The stop bit halts the count on the next edge, mid-period if need be, and forces the waveform to its inactive level. Register writes take effect on the clock edge that samples them. A read returns data one cycle after the cycle in which the read strobe is high.

Top module: `tri_pwm_timer`

## Requirements
- R1: Each channel register sits at a group base plus 4 × channel index. The group bases are: clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, match 0x30. `bus_rdata` presents the addressed register on the cycle after `bus_re` is sampled. Writing one address leaves every other register unchanged.
- R2: Clock control bits are: bit 0 prescaler on, bits 4:1 prescale exponent N, bit 5 source-select flag (stored and read back only). With the prescaler off, a running counter advances by one on every clock.
- R3: With the prescaler on, a running counter advances once every 2^(N+1) clocks, for N = 0 to 15.
- R4: Counter control bits are: bit 0 stop, bit 1 interval mode, bit 3 match mode, bit 4 counter reset, bit 5 waveform off (active high), bit 6 polarity. After reset, counter control reads 0x21. Clock control, count, interval and match read 0 after reset.
- R5: While stop is set, the count holds its value.
- R6: Writing bit 4 of counter control zeroes the count and the prescaler phase on the following edge. The bit then reads back as 0.
- R7: In interval mode the count steps 0, 1, …, interval, 0, … so one period lasts interval+1 ticks. Outside interval mode it counts freely and wraps at 2^16−1 (default width).
- R8: In match mode, a running channel's waveform is active while count < match, which gives match ticks of active level per period. With match mode off, the waveform stays inactive.
- R9: Polarity 1 makes the active level high. Polarity 0 makes the active level low.
- R10: A match of 0 gives a constantly inactive waveform. A match greater than the interval gives a constantly active waveform.
- R11: A stopped channel drives its inactive level (low when polarity is 1, high when polarity is 0). After reset, `wave_o` is all ones.
- R12: `wave_oe` for a channel is the inverse of its waveform-off bit, one cycle after the register changes. It is 0 after reset.
- R13: The count register is read-only. Writes to its address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wave_o | output | 3 | Waveform per channel |
| wave_oe | output | 3 | Waveform output enable per channel |

## Verification
Counter timing is checked by running a channel for a fixed number of clocks and reading the count back. The runs are free-running, prescaled by 2 and by 8, and wrapping at an interval. This separates a prescaler that ticks early or late from a wrap that comes one value off. Waveforms are measured over whole periods by counting active samples and rising edges. The settings cover a mid duty point, each polarity, match mode off, a match of zero and a match above the interval. The duty count catches a comparator that is off by one, and the edge count catches a wrong period. Two further channels run with different periods and prescale, which shows that the channels do not share state.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  localparam int unsigned OFS_CLK   = 'h00;
  localparam int unsigned OFS_CTL   = 'h0C;
  localparam int unsigned OFS_CNT   = 'h18;
  localparam int unsigned OFS_INT   = 'h24;
  localparam int unsigned OFS_MAT   = 'h30;
  localparam int unsigned CH_STRIDE = 4;
  localparam int unsigned PSV_W     = 4;

  typedef struct packed {
    logic             src;
    logic [PSV_W-1:0] psv;
    logic             ps_en;
  } clk_ctl_t;

  typedef struct packed {
    logic pol;
    logic wave_off;
    logic cnt_rst;
    logic mmode;
    logic rsv;
    logic imode;
    logic stop;
  } cnt_ctl_t;

  localparam cnt_ctl_t CTL_RESET = '{pol: 1'b0, wave_off: 1'b1, cnt_rst: 1'b0,
                                     mmode: 1'b0, rsv: 1'b0, imode: 1'b0, stop: 1'b1};
endpackage

// File: rtl/tpt_chan_regs.sv
module tpt_chan_regs
  import tpt_pkg::*;
#(
  parameter int unsigned CH     = 0,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  output clk_ctl_t          clk_ctl,
  output cnt_ctl_t          cnt_ctl,
  output logic [CNT_W-1:0]  interval,
  output logic [CNT_W-1:0]  match,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CH_OFS = CH_STRIDE * CH;

  logic hit_clk, hit_ctl, hit_cnt, hit_int, hit_mat;

  assign hit_clk = (addr == ADDR_W'(OFS_CLK + CH_OFS));
  assign hit_ctl = (addr == ADDR_W'(OFS_CTL + CH_OFS));
  assign hit_cnt = (addr == ADDR_W'(OFS_CNT + CH_OFS));
  assign hit_int = (addr == ADDR_W'(OFS_INT + CH_OFS));
  assign hit_mat = (addr == ADDR_W'(OFS_MAT + CH_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_ctl  <= '0;
      cnt_ctl  <= CTL_RESET;
      interval <= '0;
      match    <= '0;
    end else begin
      // counter reset bit lives for a single cycle (R6)
      cnt_ctl.cnt_rst <= 1'b0;
      if (wr_en && hit_clk) clk_ctl <= clk_ctl_t'(wdata[5:0]);
      if (wr_en && hit_ctl) begin
        cnt_ctl     <= cnt_ctl_t'(wdata[6:0]);
        cnt_ctl.rsv <= 1'b0;
      end
      if (wr_en && hit_int) interval <= wdata;
      if (wr_en && hit_mat) match    <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_clk) rd_data = DATA_W'(clk_ctl);
    if (hit_ctl) rd_data = DATA_W'(cnt_ctl);
    if (hit_cnt) rd_data = DATA_W'(count);
    if (hit_int) rd_data = DATA_W'(interval);
    if (hit_mat) rd_data = DATA_W'(match);
  end
endmodule

// File: rtl/tpt_prescaler.sv
module tpt_prescaler #(
  parameter int unsigned PSV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             en,
  input  logic [PSV_W-1:0] psv,
  output logic             tick
);
  localparam int unsigned PS_W = 1 << PSV_W;
  localparam logic [PSV_W-1:0] PSV_MAX = '1;

  logic [PS_W-1:0] phase;
  logic [PS_W-1:0] limit;
  logic            last;

  assign limit = {PS_W{1'b1}} >> (PSV_MAX - psv);
  assign last  = !en || (phase == limit);
  assign tick  = run && last;

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (run) begin
      if (last) phase <= '0;
      else      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/tpt_chan_core.sv
module tpt_chan_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             stop,
  input  logic             imode,
  input  logic             mmode,
  input  logic             pol,
  input  logic             wave_off,
  input  logic [CNT_W-1:0] interval,
  input  logic [CNT_W-1:0] match,
  output logic [CNT_W-1:0] count,
  output logic             wave,
  output logic             wave_oe
);
  logic active;

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (tick) begin
      if (imode && count == interval) count <= '0;
      else                            count <= count + 1'b1;
    end
  end

  assign active = !stop && mmode && (count < match);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave    <= 1'b1;
      wave_oe <= 1'b0;
    end else begin
      wave    <= pol ? active : !active;
      wave_oe <= !wave_off;
    end
  end
endmodule

// File: rtl/tri_pwm_timer.sv
module tri_pwm_timer
  import tpt_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    wave_o,
  output logic [NCH-1:0]    wave_oe
);
  logic [NCH-1:0][CNT_W-1:0]  ch_count, ch_interval, ch_match;
  logic [NCH-1:0][DATA_W-1:0] ch_rd;
  logic [NCH-1:0]             ch_stop, ch_rst, ch_imode, ch_mmode, ch_pol, ch_woff, ch_tick;
  logic [DATA_W-1:0]          rd_any;
  logic                       unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    clk_ctl_t clk_ctl;
    cnt_ctl_t cnt_ctl;

    tpt_chan_regs #(.CH(c), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(bus_we), .addr(bus_addr),
      .wdata(bus_wdata[CNT_W-1:0]), .count(ch_count[c]),
      .clk_ctl(clk_ctl), .cnt_ctl(cnt_ctl),
      .interval(ch_interval[c]), .match(ch_match[c]), .rd_data(ch_rd[c])
    );

    assign ch_stop[c]  = cnt_ctl.stop;
    assign ch_rst[c]   = cnt_ctl.cnt_rst;
    assign ch_imode[c] = cnt_ctl.imode;
    assign ch_mmode[c] = cnt_ctl.mmode;
    assign ch_pol[c]   = cnt_ctl.pol;
    assign ch_woff[c]  = cnt_ctl.wave_off;

    tpt_prescaler #(.PSV_W(PSV_W)) u_ps (
      .clk(clk), .rst(rst), .clr(cnt_ctl.cnt_rst), .run(!cnt_ctl.stop),
      .en(clk_ctl.ps_en), .psv(clk_ctl.psv), .tick(ch_tick[c])
    );

    tpt_chan_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst(rst), .clr(cnt_ctl.cnt_rst), .tick(ch_tick[c]),
      .stop(cnt_ctl.stop), .imode(cnt_ctl.imode), .mmode(cnt_ctl.mmode),
      .pol(cnt_ctl.pol), .wave_off(cnt_ctl.wave_off),
      .interval(ch_interval[c]), .match(ch_match[c]),
      .count(ch_count[c]), .wave(wave_o[c]), .wave_oe(wave_oe[c])
    );
  end

  always_comb begin
    rd_any = '0;
    for (int c = 0; c < NCH; c++) rd_any = rd_any | ch_rd[c];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_any;
  end
endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
  parameter int unsigned NCH   = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            wave_o,
  input logic [NCH-1:0]            wave_oe,
  input logic [NCH-1:0][CNT_W-1:0] count,
  input logic [NCH-1:0][CNT_W-1:0] interval,
  input logic [NCH-1:0][CNT_W-1:0] match,
  input logic [NCH-1:0]            stop,
  input logic [NCH-1:0]            crst,
  input logic [NCH-1:0]            imode,
  input logic [NCH-1:0]            mmode,
  input logic [NCH-1:0]            pol,
  input logic [NCH-1:0]            woff,
  input logic [NCH-1:0]            tick
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
      crst[c] |=> !crst[c]); // R6
    AST_RST_ZEROES_COUNT: assert property (@(posedge clk) disable iff (rst)
      crst[c] |=> count[c] == '0); // R6
    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
      (stop[c] && !crst[c]) |=> $stable(count[c])); // R5
    AST_INTERVAL_WRAP: assert property (@(posedge clk) disable iff (rst)
      (tick[c] && imode[c] && !crst[c] && count[c] == interval[c]) |=> count[c] == '0); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick[c] && !crst[c] && !(imode[c] && count[c] == interval[c]))
        |=> count[c] == CNT_W'($past(count[c]) + 1'b1)); // R2
    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
      (stop[c] || !mmode[c] || match[c] == '0) |=> wave_o[c] == !$past(pol[c])); // R11
    AST_OVER_MATCH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      (!stop[c] && mmode[c] && imode[c] && match[c] > interval[c] && count[c] <= interval[c])
        |=> wave_o[c] == $past(pol[c])); // R10
    AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
      woff[c] |=> !wave_oe[c]); // R12
    AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
      !woff[c] |=> wave_oe[c]); // R12
  end
endmodule

bind tri_pwm_timer tpt_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wave_o(wave_o), .wave_oe(wave_oe),
  .count(ch_count), .interval(ch_interval), .match(ch_match),
  .stop(ch_stop), .crst(ch_rst), .imode(ch_imode), .mmode(ch_mmode),
  .pol(ch_pol), .woff(ch_woff), .tick(ch_tick)
);

// File: tb/tri_pwm_timer_bench.sv
`timescale 1ns/1ps
module tri_pwm_timer_bench;
  localparam logic [31:0] STOP = 32'h01, IMODE = 32'h02, MMODE = 32'h08,
                          CRST = 32'h10, WOFF = 32'h20, POL = 32'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  wave_o, wave_oe;

  int n_cmp = 0, n_bad = 0;
  logic re_d = 1'b0;
  bit   done = 1'b0;
  string       tag_q[$];
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  tri_pwm_timer u_tri_pwm_timer (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wave_o(wave_o), .wave_oe(wave_oe)
  );

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endfunction

  // monitor: compares each read result against the queued expectation
  always @(posedge clk) re_d <= bus_re;
  always @(negedge clk) begin
    if (re_d) begin
      if (exp_q.size() == 0) chk("read with no expectation", bus_rdata, 32'hDEAD);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    tag_q.push_back(tag); exp_q.push_back(exp);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int ch, input logic [31:0] clkc, input logic [31:0] ivl,
                     input logic [31:0] mat, input logic [31:0] ctl);
    wr(8'(8'h0C + 4 * ch), STOP | CRST);
    wr(8'(8'h00 + 4 * ch), clkc);
    wr(8'(8'h24 + 4 * ch), ivl);
    wr(8'(8'h30 + 4 * ch), mat);
    wr(8'(8'h0C + 4 * ch), ctl);
  endtask

  task automatic measure(input int ch, input int n, input int exp_ones,
                         input int exp_rises, input string tag);
    int ones;
    int rises;
    logic prev;
    logic cur;
    ones = 0; rises = 0;
    @(negedge clk);
    prev = wave_o[ch];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = wave_o[ch];
      if (cur) ones++;
      if (cur && !prev) rises++;
      prev = cur;
    end
    chk({tag, " active samples"}, 32'(ones), 32'(exp_ones));
    if (exp_rises >= 0) chk({tag, " rising edges"}, 32'(rises), 32'(exp_rises));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4 / R11 / R12: reset state
    chk("R11 reset wave_o", 32'(wave_o), 32'h7);
    chk("R12 reset wave_oe", 32'(wave_oe), 32'h0);
    rd(8'h00, 32'h00, "R4 ch0 clock ctrl reset");
    rd(8'h10, 32'h21, "R4 ch1 counter ctrl reset");
    rd(8'h20, 32'h00, "R4 ch2 count reset");
    rd(8'h28, 32'h00, "R4 ch1 interval reset");

    // R1: register map and independence
    wr(8'h2C, 32'h1234);
    wr(8'h34, 32'h0042);
    rd(8'h2C, 32'h1234, "R1 ch2 interval readback");
    rd(8'h34, 32'h0042, "R1 ch1 match readback");
    rd(8'h24, 32'h0000, "R1 ch0 interval untouched");
    rd(8'h30, 32'h0000, "R1 ch0 match untouched");

    // R13: count is read-only
    wr(8'h1C, 32'h00AA);
    rd(8'h1C, 32'h0000, "R13 count write ignored");

    // R2 / R5: free run 10 clocks without prescale, then hold
    wr(8'h0C, STOP | CRST);
    idle(1);
    wr(8'h0C, 32'h0);
    idle(9);
    wr(8'h0C, STOP);
    rd(8'h18, 32'd10, "R2 count after 10 clocks");
    idle(5);
    rd(8'h18, 32'd10, "R5 count held while stopped");

    // R6: reset bit zeroes count and self-clears
    wr(8'h0C, STOP | CRST);
    idle(1);
    rd(8'h0C, STOP, "R6 reset bit reads back 0");
    rd(8'h18, 32'd0, "R6 count zeroed");

    // R3: prescale N=0 (divide by 2), 20 clocks
    wr(8'h00, 32'h01);
    wr(8'h0C, 32'h0);
    idle(19);
    wr(8'h0C, STOP);
    rd(8'h18, 32'd10, "R3 divide by 2");
    // R3: prescale N=2 (divide by 8), 40 clocks
    wr(8'h0C, STOP | CRST);
    wr(8'h00, 32'h05);
    wr(8'h0C, 32'h0);
    idle(39);
    wr(8'h0C, STOP);
    rd(8'h18, 32'd5, "R3 divide by 8");

    // R7: interval 9, 25 clocks -> 25 mod 10
    cfg(0, 32'h0, 32'd9, 32'd0, IMODE);
    idle(24);
    wr(8'h0C, STOP | IMODE);
    rd(8'h18, 32'd5, "R7 interval wrap");

    // R8 / R9: interval 9, match 4
    cfg(0, 32'h0, 32'd9, 32'd4, IMODE | MMODE | POL);
    idle(20);
    measure(0, 100, 40, 10, "R8 duty 4 of 10");
    chk("R12 wave_oe on", 32'(wave_oe[0]), 32'h1);
    wr(8'h0C, IMODE | MMODE);
    idle(20);
    measure(0, 100, 60, 10, "R9 inverted polarity");
    wr(8'h0C, IMODE | POL);
    idle(20);
    measure(0, 100, 0, -1, "R8 match mode off");

    // R10: match boundaries
    wr(8'h0C, IMODE | MMODE | POL);
    wr(8'h30, 32'd0);
    idle(20);
    measure(0, 100, 0, -1, "R10 match zero");
    wr(8'h30, 32'd12);
    idle(20);
    measure(0, 100, 100, -1, "R10 match above interval");

    // R11: stopped channel drives inactive level
    wr(8'h0C, STOP | IMODE | MMODE | POL);
    idle(3);
    measure(0, 20, 0, -1, "R11 stopped, polarity 1");
    wr(8'h0C, STOP | IMODE | MMODE);
    idle(3);
    measure(0, 20, 20, -1, "R11 stopped, polarity 0");

    // R12: waveform off bit
    wr(8'h0C, WOFF | IMODE | MMODE | POL);
    idle(2);
    chk("R12 wave_oe off", 32'(wave_oe[0]), 32'h0);

    // R1 / R3 / R8: two more channels with distinct settings
    cfg(1, 32'h0, 32'd4, 32'd2, IMODE | MMODE | POL);
    cfg(2, 32'h01, 32'd7, 32'd6, IMODE | MMODE | POL);
    idle(20);
    measure(1, 100, 40, 20, "R8 ch1 period 5 duty 2");
    measure(2, 96, 72, 6, "R3 ch2 prescaled period 16 duty 12");

    idle(3);
    if (exp_q.size() != 0) chk("R1 reads outstanding", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule